// File: doc/BRIEF.md
# Power Mode and Wake-up Controller

This block steps a processor subsystem through four power modes (full speed, reduced-speed, CPU-halted and powered-down) and drives the enables that a clock and power network needs. Software asks for a mode by pulsing request strobes. The controller latches each request and makes the move only along the permitted paths. It then drives a CPU clock enable, a peripheral clock enable, a PLL enable, a slow/PLL clock select and the enable of the switchable core supply.

In the reduced-speed mode the core runs from the reference clock divided by a programmable value, and the PLL may be switched off. When software leaves that mode, the controller keeps the slow clock selected until the PLL has been enabled for a programmable number of lock cycles. In the powered-down mode only the always-on wake logic is live. Any of the external wake lines restarts the core unless the battery fault input is high. A restart holds an internal reset for a long fixed count and records that the restart came from a wake and not from a cold power-up.

Top module: `pmc_ctrl`

## Requirements
- R1: While and after a cold reset (`rst` high), the outputs are `cpu_clk_en`=1, `per_clk_en`=1, `pll_en`=1, `clk_sel_slow`=0, `core_pwr_en`=1, `wake_rst`=0, `mode_o`=0, `woke_from_off`=0 and `batt_irq`=0.
- R2: The mode code on `mode_o` is 0 for NORMAL, 1 for SLOW (including the lock wait), 2 for IDLE and 3 for POWER_OFF (including the wake reset). In NORMAL all three clock and power enables and `pll_en` are 1, and `clk_sel_slow` is 0.
- R3: A `set_slow` pulse in NORMAL enters SLOW. There `clk_sel_slow` is 1, and `cpu_clk_en` and `per_clk_en` are each high for exactly one cycle in every `slow_div`+1 cycles.
- R4: `pll_en` follows `pll_on` only in SLOW. It is 1 in NORMAL, IDLE and during the wake reset, and 0 in POWER_OFF.
- R5: A `clr_slow` pulse leaves SLOW and forces `pll_en` to 1. If the PLL has not yet been enabled for `lock_cycles` consecutive cycles, `clk_sel_slow` stays 1 and `mode_o` stays 1 until that count completes, and then NORMAL is resumed. If the PLL is already locked, NORMAL returns within two cycles.
- R6: An IDLE request is taken only in a cycle when `cpu_ack` is 1. In IDLE, `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R7: Any bit of `irq` set in IDLE returns to NORMAL. All latched requests are cleared whenever NORMAL is re-entered, so a later `cpu_ack` without a new request does not re-enter IDLE.
- R8: A latched POWER_OFF request wins over IDLE and SLOW requests. In POWER_OFF, `core_pwr_en`, `cpu_clk_en`, `per_clk_en` and `pll_en` are all 0.
- R9: In POWER_OFF with `batt_fault` low, a high level on any single bit of `ext_wake` starts the wake reset.
- R10: In POWER_OFF with `batt_fault` high, every `ext_wake` bit is ignored: `core_pwr_en` and `wake_rst` stay 0.
- R11: `batt_irq` repeats `batt_fault` one cycle later while the controller is outside POWER_OFF and the wake reset, and it is 0 inside them.
- R12: The wake reset holds `wake_rst`=1 and `core_pwr_en`=1 for exactly WAKE_CYCLES cycles (default 65535). Wake line activity during the count neither restarts nor extends it.
- R13: `woke_from_off` becomes 1 when a wake reset ends and stays 1 until the next cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Cold power-up reset, synchronous, active high |
| set_slow | input | 1 | Pulse: request SLOW |
| clr_slow | input | 1 | Pulse: withdraw the SLOW request |
| set_idle | input | 1 | Pulse: request IDLE |
| set_off | input | 1 | Pulse: request POWER_OFF |
| slow_div | input | DIV_W | Slow clock divide value (period is value+1) |
| pll_on | input | 1 | PLL on request, honoured in SLOW only |
| lock_cycles | input | LOCK_W | PLL lock wait length in cycles |
| cpu_ack | input | 1 | CPU acknowledge for IDLE entry |
| irq | input | IRQ_W | Interrupt requests |
| ext_wake | input | WAKE_W | External wake lines |
| batt_fault | input | 1 | Battery fault, active high |
| cpu_clk_en | output | 1 | CPU core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| clk_sel_slow | output | 1 | 1 selects the divided slow clock |
| core_pwr_en | output | 1 | Switchable core supply enable |
| wake_rst | output | 1 | Internal reset during wake |
| mode_o | output | 2 | Current mode code |
| woke_from_off | output | 1 | Last restart was a wake from POWER_OFF |
| batt_irq | output | 1 | Level battery fault interrupt |

## Verification
A wrong state register shows at once on `mode_o` and on the enable outputs, because every output is registered from the next state: a wrong decision is visible one cycle after the deciding edge. A divider fault shows as a wrong count of clock enable pulses within one divide period. A faulty lock or wake counter shows as a return to NORMAL at the wrong time. The wake length is measured to the exact cycle, and the lock wait is bracketed by a sample inside it and one after it. A lost request clear shows as an unwanted re-entry into IDLE or POWER_OFF within a few cycles of returning to NORMAL.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_NORM = 3'd0,
    ST_SLOW = 3'd1,
    ST_LOCK = 3'd2,
    ST_IDLE = 3'd3,
    ST_OFF  = 3'd4,
    ST_WAKE = 3'd5
  } pmc_state_t;

  typedef struct packed {
    logic slow;
    logic idle;
    logic off;
  } pmc_req_t;

  localparam logic [1:0] MC_NORMAL = 2'd0;
  localparam logic [1:0] MC_SLOW   = 2'd1;
  localparam logic [1:0] MC_IDLE   = 2'd2;
  localparam logic [1:0] MC_OFF    = 2'd3;

  function automatic logic [1:0] mode_code(input pmc_state_t s);
    case (s)
      ST_SLOW, ST_LOCK: mode_code = MC_SLOW;
      ST_IDLE:          mode_code = MC_IDLE;
      ST_OFF, ST_WAKE:  mode_code = MC_OFF;
      default:          mode_code = MC_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/pmc_slow_div.sv
module pmc_slow_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_lock_timer.sv
module pmc_lock_timer #(
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_en,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic              locked
);
  logic [LOCK_W-1:0] cnt_q;
  logic [LOCK_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !pll_en) begin
      cnt_q  <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (cnt_inc >= {1'b0, lock_cycles}) locked <= 1'b1;
      else cnt_q <= cnt_inc[LOCK_W-1:0];
    end
  end
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
  parameter int CYCLES = 65535
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int LOCK_W      = 16,
  parameter int IRQ_W       = 8,
  parameter int WAKE_W      = 16,
  parameter int WAKE_CYCLES = 65535
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_slow,
  input  logic              clr_slow,
  input  logic              set_idle,
  input  logic              set_off,
  input  logic [DIV_W-1:0]  slow_div,
  input  logic              pll_on,
  input  logic [LOCK_W-1:0] lock_cycles,
  input  logic              cpu_ack,
  input  logic [IRQ_W-1:0]  irq,
  input  logic [WAKE_W-1:0] ext_wake,
  input  logic              batt_fault,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              pll_en,
  output logic              clk_sel_slow,
  output logic              core_pwr_en,
  output logic              wake_rst,
  output logic [1:0]        mode_o,
  output logic              woke_from_off,
  output logic              batt_irq
);

  pmc_state_t state_q, state_d;
  pmc_req_t   req_q;
  logic       slow_run, slow_tick, locked, wake_done;
  logic       nxt_slowlike, back_to_norm;

  assign slow_run = (state_q == ST_SLOW) || (state_q == ST_LOCK);

  pmc_slow_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(slow_run), .div(slow_div), .tick(slow_tick)
  );

  pmc_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .pll_en(pll_en), .lock_cycles(lock_cycles), .locked(locked)
  );

  pmc_wake_timer #(.CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .run(state_q == ST_WAKE), .done(wake_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_NORM: begin
        if (req_q.off)                   state_d = ST_OFF;
        else if (req_q.idle && cpu_ack)  state_d = ST_IDLE;
        else if (req_q.slow)             state_d = ST_SLOW;
      end
      ST_SLOW: if (!req_q.slow) state_d = locked ? ST_NORM : ST_LOCK;
      ST_LOCK: if (locked) state_d = ST_NORM;
      ST_IDLE: if (|irq) state_d = ST_NORM;
      ST_OFF:  if ((|ext_wake) && !batt_fault) state_d = ST_WAKE;
      ST_WAKE: if (wake_done) state_d = ST_NORM;
      default: state_d = ST_NORM;
    endcase
  end

  assign nxt_slowlike = (state_d == ST_SLOW) || (state_d == ST_LOCK);
  assign back_to_norm = (state_q != ST_NORM) && (state_d == ST_NORM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_NORM;
      req_q         <= '0;
      cpu_clk_en    <= 1'b1;
      per_clk_en    <= 1'b1;
      pll_en        <= 1'b1;
      clk_sel_slow  <= 1'b0;
      core_pwr_en   <= 1'b1;
      wake_rst      <= 1'b0;
      mode_o        <= MC_NORMAL;
      woke_from_off <= 1'b0;
      batt_irq      <= 1'b0;
    end else begin
      state_q <= state_d;

      if (back_to_norm) begin
        req_q <= '0;
      end else begin
        if (set_slow)      req_q.slow <= 1'b1;
        else if (clr_slow) req_q.slow <= 1'b0;
        if (set_idle)      req_q.idle <= 1'b1;
        if (set_off)       req_q.off  <= 1'b1;
      end

      case (state_d)
        ST_NORM: begin cpu_clk_en <= 1'b1; per_clk_en <= 1'b1; end
        ST_IDLE: begin cpu_clk_en <= 1'b0; per_clk_en <= 1'b1; end
        ST_WAKE: begin cpu_clk_en <= 1'b0; per_clk_en <= 1'b1; end
        ST_OFF:  begin cpu_clk_en <= 1'b0; per_clk_en <= 1'b0; end
        default: begin cpu_clk_en <= slow_tick; per_clk_en <= slow_tick; end
      endcase

      if (state_d == ST_SLOW)     pll_en <= pll_on;
      else if (state_d == ST_OFF) pll_en <= 1'b0;
      else                        pll_en <= 1'b1;

      clk_sel_slow <= nxt_slowlike;
      core_pwr_en  <= (state_d != ST_OFF);
      wake_rst     <= (state_d == ST_WAKE);
      mode_o       <= mode_code(state_d);
      batt_irq     <= batt_fault && (state_d != ST_OFF) && (state_d != ST_WAKE);
      if ((state_q == ST_WAKE) && (state_d == ST_NORM)) woke_from_off <= 1'b1;
    end
  end

endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       pll_en,
  input logic       clk_sel_slow,
  input logic       core_pwr_en,
  input logic       wake_rst,
  input logic [1:0] mode_o,
  input logic       woke_from_off,
  input logic       batt_irq,
  input logic       batt_fault
);

  // R8
  off_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    !core_pwr_en |-> (!cpu_clk_en && !per_clk_en && !pll_en));

  // R12
  wake_power_chk: assert property (@(posedge clk) disable iff (rst)
    wake_rst |-> (core_pwr_en && mode_o == 2'd3));

  // R6
  idle_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> (!cpu_clk_en && per_clk_en));

  // R4
  pll_off_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_en |-> (mode_o == 2'd1 || mode_o == 2'd3));

  // R3
  slow_sel_chk: assert property (@(posedge clk) disable iff (rst)
    clk_sel_slow |-> (mode_o == 2'd1));

  // R10
  batt_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3 && !core_pwr_en && batt_fault) |=> !wake_rst);

  // R13
  wake_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_rst) |-> woke_from_off);

  // R11
  batt_irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    batt_irq |-> (mode_o != 2'd3));

endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .pll_en(pll_en), .clk_sel_slow(clk_sel_slow), .core_pwr_en(core_pwr_en),
  .wake_rst(wake_rst), .mode_o(mode_o), .woke_from_off(woke_from_off),
  .batt_irq(batt_irq), .batt_fault(batt_fault)
);

// File: tb/sim_pmc_ctrl.sv
module sim_pmc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_slow = 0, clr_slow = 0, set_idle = 0, set_off = 0;
  logic [7:0]  slow_div = 8'd3;
  logic        pll_on = 1'b1;
  logic [15:0] lock_cycles = 16'd40;
  logic        cpu_ack = 0;
  logic [7:0]  irq = '0;
  logic [15:0] ext_wake = '0;
  logic        batt_fault = 0;
  logic        cpu_clk_en, per_clk_en, pll_en, clk_sel_slow, core_pwr_en;
  logic        wake_rst, woke_from_off, batt_irq;
  logic [1:0]  mode_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pmc_ctrl u0 (
    .clk(clk), .rst(rst), .set_slow(set_slow), .clr_slow(clr_slow),
    .set_idle(set_idle), .set_off(set_off), .slow_div(slow_div), .pll_on(pll_on),
    .lock_cycles(lock_cycles), .cpu_ack(cpu_ack), .irq(irq), .ext_wake(ext_wake),
    .batt_fault(batt_fault), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .pll_en(pll_en), .clk_sel_slow(clk_sel_slow), .core_pwr_en(core_pwr_en),
    .wake_rst(wake_rst), .mode_o(mode_o), .woke_from_off(woke_from_off),
    .batt_irq(batt_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(3);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 core_pwr_en", core_pwr_en, 1);
    chk("R1 mode", mode_o, 0);
    chk("R1 woke", woke_from_off, 0);
    chk("R1 wake_rst", wake_rst, 0);
    rst = 1'b0;
    cyc(2);
    chk("R1 batt_irq", batt_irq, 0);
    chk("R13 cold flag", woke_from_off, 0);
  endtask

  task automatic t_normal();
    cyc(60);
    chk("R2 per_clk_en", per_clk_en, 1);
    chk("R2 pll_en", pll_en, 1);
    chk("R2 sel", clk_sel_slow, 0);
    batt_fault = 1'b1;
    cyc(2);
    chk("R11 irq high", batt_irq, 1);
    batt_fault = 1'b0;
    cyc(2);
    chk("R11 irq low", batt_irq, 0);
  endtask

  task automatic t_slow_pll_off();
    int n_cpu = 0;
    int n_per = 0;
    pll_on = 1'b0;
    set_slow = 1'b1; cyc(1); set_slow = 1'b0;
    cyc(4);
    chk("R3 mode slow", mode_o, 1);
    chk("R3 sel slow", clk_sel_slow, 1);
    chk("R4 pll follows", pll_en, 0);
    for (int i = 0; i < 40; i++) begin
      if (cpu_clk_en) n_cpu++;
      if (per_clk_en) n_per++;
      cyc(1);
    end
    chk("R3 cpu pulses", n_cpu, 10);
    chk("R3 per pulses", n_per, 10);
    clr_slow = 1'b1; cyc(1); clr_slow = 1'b0;
    cyc(10);
    chk("R5 sel during lock", clk_sel_slow, 1);
    chk("R5 mode during lock", mode_o, 1);
    chk("R5 pll forced", pll_en, 1);
    cyc(50);
    chk("R5 mode after lock", mode_o, 0);
    chk("R5 sel after lock", clk_sel_slow, 0);
    chk("R2 cpu after lock", cpu_clk_en, 1);
  endtask

  task automatic t_slow_pll_on();
    pll_on = 1'b1;
    set_slow = 1'b1; cyc(1); set_slow = 1'b0;
    cyc(60);
    chk("R4 pll on in slow", pll_en, 1);
    clr_slow = 1'b1; cyc(1); clr_slow = 1'b0;
    cyc(3);
    chk("R5 direct return", mode_o, 0);
  endtask

  task automatic t_idle();
    set_idle = 1'b1; cyc(1); set_idle = 1'b0;
    cyc(5);
    chk("R6 no ack mode", mode_o, 0);
    chk("R6 no ack cpu", cpu_clk_en, 1);
    cpu_ack = 1'b1; cyc(1); cpu_ack = 1'b0;
    cyc(1);
    chk("R6 idle mode", mode_o, 2);
    chk("R6 idle cpu", cpu_clk_en, 0);
    chk("R6 idle per", per_clk_en, 1);
    irq = 8'h20; cyc(1); irq = '0;
    cyc(1);
    chk("R7 irq exit", mode_o, 0);
    chk("R7 cpu back", cpu_clk_en, 1);
    cpu_ack = 1'b1; cyc(1); cpu_ack = 1'b0;
    cyc(2);
    chk("R7 request cleared", mode_o, 0);
  endtask

  task automatic t_off();
    set_off = 1'b1; set_idle = 1'b1; set_slow = 1'b1; cpu_ack = 1'b1;
    cyc(1);
    set_off = 1'b0; set_idle = 1'b0; set_slow = 1'b0; cpu_ack = 1'b0;
    cyc(3);
    chk("R8 off mode", mode_o, 3);
    chk("R8 pwr", core_pwr_en, 0);
    chk("R8 cpu", cpu_clk_en, 0);
    chk("R8 per", per_clk_en, 0);
    chk("R4 pll off", pll_en, 0);
    batt_fault = 1'b1;
    cyc(2);
    chk("R11 masked in off", batt_irq, 0);
    ext_wake = 16'h8000; cyc(3); ext_wake = '0;
    cyc(2);
    chk("R10 pwr stays off", core_pwr_en, 0);
    chk("R10 no wake rst", wake_rst, 0);
    batt_fault = 1'b0;
    cyc(3);
    chk("R10 still off", mode_o, 3);
  endtask

  task automatic t_wake();
    int n = 0;
    ext_wake = 16'h0004; cyc(1); ext_wake = '0;
    chk("R9 wake start", wake_rst, 1);
    chk("R12 power on", core_pwr_en, 1);
    while (wake_rst && n < 70000) begin
      n++;
      if (n == 100) ext_wake = 16'hffff;
      if (n == 103) ext_wake = '0;
      cyc(1);
    end
    chk("R12 wake length", n, 65535);
    chk("R13 woke flag", woke_from_off, 1);
    chk("R9 mode normal", mode_o, 0);
    cyc(5);
    chk("R7 off request cleared", mode_o, 0);
    chk("R2 cpu after wake", cpu_clk_en, 1);
    chk("R13 flag kept", woke_from_off, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_slow_pll_off();
    t_slow_pll_on();
    t_idle();
    t_off();
    t_wake();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule